// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Store

This block is a write-back data cache that sits between a processor port and a line-wide port to the next memory level. Each request carries a byte address, a read/write flag, byte enables and write data. The cache returns one 32-bit line word and a flag that says whether the request was served without a memory fetch. The main store is direct-mapped, so every memory block has exactly one home line, chosen by the index field of the address.

A line that leaves the direct-mapped store is not dropped. It moves into a small, fully associative victim store. On a primary miss, every victim entry is compared with the request in parallel. If one matches, that entry and the current occupant of the indexed line trade places, and no memory traffic is needed. Victim entries are recycled in first-in, first-out order. A modified entry is written to the next level only when it is pushed out of the victim store.

Only one request is in flight at a time. `req_ready` is high only while the cache is idle.

Top module: `victim_cache_top`

## Requirements
- R1: After reset, every line of both stores is invalid. `req_ready` is 1, `resp_valid` is 0 and both memory requests are 0. The first access to any block reports `resp_hit`=0 and reads memory once.
- R2: The address is split as follows. Bits [1:0] are the byte offset. Bits [INDEX_W+1:2] are the line index. The bits above that are the tag, so the defaults give a 16-bit tag, a 6-bit index and a 2-bit offset; INDEX_W=14 gives the 8/14/2 layout. A response returns the whole 4-byte line word, with byte k on bits [8k+7:8k], whatever the offset is. On a write, byte enable bit k updates byte k only.
- R3: A line hits when it is valid and its stored tag equals the address tag. A hit in the direct-mapped store raises `resp_valid` with `resp_hit`=1 one cycle after the acceptance cycle, with no memory request.
- R4: The victim store holds VB_DEPTH lines (4 to 16). Each entry stores the full 22-bit block address and is compared in parallel, and at most one entry ever matches.
- R5: A primary miss that hits the victim store swaps the two lines, modified bits included. It answers with `resp_hit`=1 one cycle later than a primary hit, with no memory read.
- R6: A write changes only the cached copy and marks the line modified. A write hit issues no memory write.
- R7: A line is written to memory (`mem_wr_req`, with its block address and data) only when it is pushed out of the victim store while modified. Clean lines are discarded without memory traffic.
- R8: When both stores miss and the indexed line is valid, the oldest victim entry, in FIFO order, is replaced, and the indexed line takes its slot.
- R9: When both stores miss, `mem_rd_req` is raised with the block address (address bits above the offset). The request and the address are held until `mem_rd_valid`. The response reports `resp_hit`=0.
- R10: `req_ready` is 0 from the cycle after acceptance until the response. `resp_valid` is a one-cycle pulse.
- R11: A read always returns the latest value written to that block, including after the block has been evicted, written back and fetched again.
- R12: Two blocks that share an index can be accessed alternately without further memory reads after the first access to each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Served without a memory fetch |
| resp_rdata | output | 32 | Line word (merged value after a write) |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_addr | output | ADDR_W-2 | Block address to fetch |
| mem_rd_valid | input | 1 | Fetch data present |
| mem_rd_data | input | 32 | Fetched line |
| mem_wr_req | output | 1 | Line write-back request |
| mem_wr_addr | output | ADDR_W-2 | Block address written back |
| mem_wr_data | output | 32 | Line written back |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
Several kinds of internal error show up at the ports. A stale tag or a lost valid bit shows as a wrong `resp_hit` or an extra `mem_rd_req` on the very access that uses the line. A swap that loses its modified bit, or a victim pointer that selects the wrong slot, stays hidden until the affected line is evicted. At that point the fault appears as a missing or extra `mem_wr_req`, or as stale data on a later re-read of the block. The bench therefore pairs every access with a behavioural model of both stores and checks data, hit flag and memory traffic counts per access. It also runs long random sequences over a few crowded indices, so that such latent faults surface within a few dozen accesses.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRBACK,
        ST_EVICT,
        ST_FETCH
    } vc_state_e;
endpackage

// File: rtl/vc_line_store.sv
module vc_line_store #(
    parameter int INDEX_W = 6,
    parameter int TAG_W   = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]  valid_d, valid_q;
    logic [LINES-1:0]  dirty_d, dirty_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
            dirty_d[wr_idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

    // A modified line must always be a valid one (R6)
    assert_dirty_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dirty) |=> (valid_q[$past(wr_idx)] && dirty_q[$past(wr_idx)]));
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
    parameter int DEPTH  = 4,
    parameter int BLK_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BLK_W-1:0]         look_blk,
    output logic                     hit,
    output logic [$clog2(DEPTH)-1:0] hit_slot,
    output logic                     hit_dirty,
    output logic [DATA_W-1:0]        hit_data,
    output logic [$clog2(DEPTH)-1:0] head_slot,
    output logic                     head_valid,
    output logic                     head_dirty,
    output logic [BLK_W-1:0]         head_blk,
    output logic [DATA_W-1:0]        head_data,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_slot,
    input  logic                     wr_valid,
    input  logic                     wr_dirty,
    input  logic [BLK_W-1:0]         wr_blk,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     adv_head
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid_d, valid_q;
    logic [DEPTH-1:0]  dirty_d, dirty_q;
    logic [SLOT_W-1:0] head_d, head_q;
    logic [BLK_W-1:0]  blk_mem  [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [DEPTH-1:0]  match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (blk_mem[g] == look_blk);
    end

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_slot = SLOT_W'(i);
        end
    end

    assign hit        = |match;
    assign hit_dirty  = dirty_q[hit_slot];
    assign hit_data   = data_mem[hit_slot];
    assign head_slot  = head_q;
    assign head_valid = valid_q[head_q];
    assign head_dirty = dirty_q[head_q];
    assign head_blk   = blk_mem[head_q];
    assign head_data  = data_mem[head_q];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        head_d  = head_q;
        if (wr_en) begin
            valid_d[wr_slot] = wr_valid;
            dirty_d[wr_slot] = wr_dirty;
        end
        if (adv_head) begin
            head_d = (head_q == SLOT_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            head_q  <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            head_q  <= head_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            blk_mem[wr_slot]  <= wr_blk;
            data_mem[wr_slot] <= wr_data;
        end
    end

    // Parallel compare never finds the same block twice (R4)
    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // FIFO pointer moves by exactly one slot per eviction (R8)
    assert_head_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_head |=> $stable(head_q));
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl #(
    parameter int ADDR_W   = 24,
    parameter int INDEX_W  = 6,
    parameter int OFF_W    = 2,
    parameter int VB_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [(1<<OFF_W)-1:0]         req_be,
    input  logic [(8<<OFF_W)-1:0]         req_wdata,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic [(8<<OFF_W)-1:0]         resp_rdata,
    output logic [INDEX_W-1:0]            dm_idx,
    input  logic                          dm_rd_valid,
    input  logic                          dm_rd_dirty,
    input  logic [ADDR_W-OFF_W-INDEX_W-1:0] dm_rd_tag,
    input  logic [(8<<OFF_W)-1:0]         dm_rd_data,
    output logic                          dm_wr_en,
    output logic                          dm_wr_valid,
    output logic                          dm_wr_dirty,
    output logic [ADDR_W-OFF_W-INDEX_W-1:0] dm_wr_tag,
    output logic [(8<<OFF_W)-1:0]         dm_wr_data,
    output logic [ADDR_W-OFF_W-1:0]       vb_look_blk,
    input  logic                          vb_hit,
    input  logic [$clog2(VB_DEPTH)-1:0]   vb_hit_slot,
    input  logic                          vb_hit_dirty,
    input  logic [(8<<OFF_W)-1:0]         vb_hit_data,
    input  logic [$clog2(VB_DEPTH)-1:0]   vb_head_slot,
    input  logic                          vb_head_valid,
    input  logic                          vb_head_dirty,
    input  logic [ADDR_W-OFF_W-1:0]       vb_head_blk,
    input  logic [(8<<OFF_W)-1:0]         vb_head_data,
    output logic                          vb_wr_en,
    output logic [$clog2(VB_DEPTH)-1:0]   vb_wr_slot,
    output logic                          vb_wr_valid,
    output logic                          vb_wr_dirty,
    output logic [ADDR_W-OFF_W-1:0]       vb_wr_blk,
    output logic [(8<<OFF_W)-1:0]         vb_wr_data,
    output logic                          vb_adv,
    output logic                          mem_rd_req,
    output logic [ADDR_W-OFF_W-1:0]       mem_rd_addr,
    input  logic                          mem_rd_valid,
    input  logic [(8<<OFF_W)-1:0]         mem_rd_data,
    output logic                          mem_wr_req,
    output logic [ADDR_W-OFF_W-1:0]       mem_wr_addr,
    output logic [(8<<OFF_W)-1:0]         mem_wr_data,
    input  logic                          mem_wr_ack
);
    import vc_pkg::*;

    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int TAG_W  = BLK_W - INDEX_W;
    localparam int DATA_W = 8 << OFF_W;
    localparam int BE_W   = 1 << OFF_W;

    typedef struct packed {
        vc_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        logic              fetched;
        logic              rv;
        logic              rh;
        logic [DATA_W-1:0] rdata;
    } ctrl_s;

    ctrl_s q, d;

    logic [BLK_W-1:0]   cur_blk;
    logic [TAG_W-1:0]   cur_tag;
    logic [INDEX_W-1:0] cur_idx;
    logic               dm_hit;
    logic [DATA_W-1:0]  merged;
    logic               unused_offset;

    assign cur_blk       = q.addr[ADDR_W-1:OFF_W];
    assign cur_tag       = q.addr[ADDR_W-1 -: TAG_W];
    assign cur_idx       = q.addr[OFF_W +: INDEX_W];
    assign unused_offset = ^q.addr[OFF_W-1:0];
    assign dm_hit        = dm_rd_valid && (dm_rd_tag == cur_tag);

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BE_W-1:0]   en
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (en[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

    assign merged = merge_bytes(dm_rd_data, q.wdata, q.be);

    always_comb begin
        d           = q;
        d.rv        = 1'b0;
        dm_wr_en    = 1'b0;
        dm_wr_valid = 1'b1;
        dm_wr_dirty = 1'b0;
        dm_wr_tag   = cur_tag;
        dm_wr_data  = dm_rd_data;
        vb_wr_en    = 1'b0;
        vb_wr_slot  = vb_head_slot;
        vb_wr_valid = dm_rd_valid;
        vb_wr_dirty = dm_rd_dirty;
        vb_wr_blk   = {dm_rd_tag, cur_idx};
        vb_wr_data  = dm_rd_data;
        vb_adv      = 1'b0;
        mem_rd_req  = 1'b0;
        mem_wr_req  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st      = ST_LOOKUP;
                    d.addr    = req_addr;
                    d.wr      = req_write;
                    d.be      = req_be;
                    d.wdata   = req_wdata;
                    d.fetched = 1'b0;
                end
            end
            ST_LOOKUP: begin
                if (dm_hit) begin
                    if (q.wr) begin
                        dm_wr_en    = 1'b1;
                        dm_wr_dirty = 1'b1;
                        dm_wr_data  = merged;
                    end
                    d.rdata = q.wr ? merged : dm_rd_data;
                    d.rv    = 1'b1;
                    d.rh    = !q.fetched;
                    d.st    = ST_IDLE;
                end else if (vb_hit) begin
                    // swap: victim line home, indexed occupant into its slot
                    dm_wr_en    = 1'b1;
                    dm_wr_dirty = vb_hit_dirty;
                    dm_wr_data  = vb_hit_data;
                    vb_wr_en    = 1'b1;
                    vb_wr_slot  = vb_hit_slot;
                end else if (dm_rd_valid) begin
                    d.st = (vb_head_valid && vb_head_dirty) ? ST_WRBACK : ST_EVICT;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_WRBACK: begin
                mem_wr_req = 1'b1;
                if (mem_wr_ack) d.st = ST_EVICT;
            end
            ST_EVICT: begin
                vb_wr_en = 1'b1;
                vb_adv   = 1'b1;
                d.st     = ST_FETCH;
            end
            ST_FETCH: begin
                mem_rd_req = 1'b1;
                if (mem_rd_valid) begin
                    dm_wr_en    = 1'b1;
                    dm_wr_dirty = 1'b0;
                    dm_wr_data  = mem_rd_data;
                    d.fetched   = 1'b1;
                    d.st        = ST_LOOKUP;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign resp_valid  = q.rv;
    assign resp_hit    = q.rh;
    assign resp_rdata  = q.rdata;
    assign dm_idx      = cur_idx;
    assign vb_look_blk = cur_blk;
    assign mem_rd_addr = cur_blk;
    assign mem_wr_addr = vb_head_blk;
    assign mem_wr_data = vb_head_data;

    // Fetch request and its address hold until data arrives (R9)
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // Only a valid, modified victim entry is ever written back (R7)
    assert_wb_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (vb_head_valid && vb_head_dirty));

    // Memory sees one kind of request at a time (R7)
    assert_no_dual_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // Response is a single-cycle pulse (R10)
    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // No second request is taken while one is open (R10)
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/victim_cache_top.sv
module victim_cache_top #(
    parameter int ADDR_W   = 24,
    parameter int INDEX_W  = 6,
    parameter int VB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [31:0]       resp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-3:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-3:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int OFF_W  = 2;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int TAG_W  = BLK_W - INDEX_W;
    localparam int DATA_W = 8 << OFF_W;
    localparam int SLOT_W = $clog2(VB_DEPTH);

    logic [INDEX_W-1:0] dm_idx;
    logic               dm_rd_valid, dm_rd_dirty;
    logic [TAG_W-1:0]   dm_rd_tag;
    logic [DATA_W-1:0]  dm_rd_data;
    logic               dm_wr_en, dm_wr_valid, dm_wr_dirty;
    logic [TAG_W-1:0]   dm_wr_tag;
    logic [DATA_W-1:0]  dm_wr_data;

    logic [BLK_W-1:0]   vb_look_blk;
    logic               vb_hit, vb_hit_dirty;
    logic [SLOT_W-1:0]  vb_hit_slot, vb_head_slot, vb_wr_slot;
    logic [DATA_W-1:0]  vb_hit_data, vb_head_data, vb_wr_data;
    logic               vb_head_valid, vb_head_dirty;
    logic [BLK_W-1:0]   vb_head_blk, vb_wr_blk;
    logic               vb_wr_en, vb_wr_valid, vb_wr_dirty, vb_adv;

    vc_line_store #(
        .INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(dm_idx), .rd_valid(dm_rd_valid), .rd_dirty(dm_rd_dirty),
        .rd_tag(dm_rd_tag), .rd_data(dm_rd_data),
        .wr_en(dm_wr_en), .wr_idx(dm_idx), .wr_valid(dm_wr_valid),
        .wr_dirty(dm_wr_dirty), .wr_tag(dm_wr_tag), .wr_data(dm_wr_data)
    );

    vc_victim_buf #(
        .DEPTH(VB_DEPTH), .BLK_W(BLK_W), .DATA_W(DATA_W)
    ) u_victims (
        .clk(clk), .rst_n(rst_n),
        .look_blk(vb_look_blk), .hit(vb_hit), .hit_slot(vb_hit_slot),
        .hit_dirty(vb_hit_dirty), .hit_data(vb_hit_data),
        .head_slot(vb_head_slot), .head_valid(vb_head_valid),
        .head_dirty(vb_head_dirty), .head_blk(vb_head_blk), .head_data(vb_head_data),
        .wr_en(vb_wr_en), .wr_slot(vb_wr_slot), .wr_valid(vb_wr_valid),
        .wr_dirty(vb_wr_dirty), .wr_blk(vb_wr_blk), .wr_data(vb_wr_data),
        .adv_head(vb_adv)
    );

    vc_ctrl #(
        .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFF_W(OFF_W), .VB_DEPTH(VB_DEPTH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .dm_idx(dm_idx), .dm_rd_valid(dm_rd_valid), .dm_rd_dirty(dm_rd_dirty),
        .dm_rd_tag(dm_rd_tag), .dm_rd_data(dm_rd_data),
        .dm_wr_en(dm_wr_en), .dm_wr_valid(dm_wr_valid), .dm_wr_dirty(dm_wr_dirty),
        .dm_wr_tag(dm_wr_tag), .dm_wr_data(dm_wr_data),
        .vb_look_blk(vb_look_blk), .vb_hit(vb_hit), .vb_hit_slot(vb_hit_slot),
        .vb_hit_dirty(vb_hit_dirty), .vb_hit_data(vb_hit_data),
        .vb_head_slot(vb_head_slot), .vb_head_valid(vb_head_valid),
        .vb_head_dirty(vb_head_dirty), .vb_head_blk(vb_head_blk),
        .vb_head_data(vb_head_data),
        .vb_wr_en(vb_wr_en), .vb_wr_slot(vb_wr_slot), .vb_wr_valid(vb_wr_valid),
        .vb_wr_dirty(vb_wr_dirty), .vb_wr_blk(vb_wr_blk), .vb_wr_data(vb_wr_data),
        .vb_adv(vb_adv),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );
endmodule

// File: tb/tb_victim_cache_top.sv
`timescale 1ns/1ps
module tb_victim_cache_top;
    localparam int ADDR_W = 24;
    localparam int IDX_W  = 6;
    localparam int LINES  = 1 << IDX_W;
    localparam int VB     = 4;
    localparam int BLK_W  = ADDR_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_hit;
    logic [31:0] resp_rdata;
    logic mem_rd_req, mem_wr_req;
    logic [BLK_W-1:0] mem_rd_addr, mem_wr_addr;
    logic mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] mem_wr_data;

    always #4 clk = ~clk;

    victim_cache_top #(.ADDR_W(ADDR_W), .INDEX_W(IDX_W), .VB_DEPTH(VB)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    int checks = 0, failures = 0;
    bit finished = 0;
    int rd_count = 0, wr_count = 0;
    int last_wr_blk = -1;
    logic [31:0] last_wr_data = '0;

    logic [31:0] backing [int];
    logic [31:0] expect_mem [int];

    // reference model of both stores
    bit m_dm_v [LINES];
    int m_dm_b [LINES];
    bit m_dm_d [LINES];
    bit m_vb_v [VB];
    int m_vb_b [VB];
    bit m_vb_d [VB];
    int m_head;

    function automatic logic [31:0] seed_word(int b);
        return (32'(b) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] back_rd(int b);
        return backing.exists(b) ? backing[b] : seed_word(b);
    endfunction

    function automatic logic [31:0] exp_rd(int b);
        return expect_mem.exists(b) ? expect_mem[b] : seed_word(b);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_access(int blk, bit wr, output bit hit, output bit wb);
        int idx = blk % LINES;
        int slot = -1;
        hit = 0; wb = 0;
        if (m_dm_v[idx] && m_dm_b[idx] == blk) begin
            hit = 1;
        end else begin
            for (int s = 0; s < VB; s++) if (m_vb_v[s] && m_vb_b[s] == blk) slot = s;
            if (slot >= 0) begin
                bit tv = m_dm_v[idx]; int tb = m_dm_b[idx]; bit td = m_dm_d[idx];
                m_dm_v[idx] = 1; m_dm_b[idx] = blk; m_dm_d[idx] = m_vb_d[slot];
                m_vb_v[slot] = tv; m_vb_b[slot] = tb; m_vb_d[slot] = td;
                hit = 1;
            end else begin
                if (m_dm_v[idx]) begin
                    wb = m_vb_v[m_head] && m_vb_d[m_head];
                    m_vb_v[m_head] = 1; m_vb_b[m_head] = m_dm_b[idx];
                    m_vb_d[m_head] = m_dm_d[idx];
                    m_head = (m_head + 1) % VB;
                end
                m_dm_v[idx] = 1; m_dm_b[idx] = blk; m_dm_d[idx] = 0;
            end
        end
        if (wr) m_dm_d[idx] = 1;
    endtask

    // next-level memory responder
    initial begin
        int rw = 0, ww = 0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_wr_ack   = 1'b0;
            if (mem_rd_req) begin
                rw++;
                if (rw == 3) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = back_rd(int'(mem_rd_addr));
                    rd_count++;
                    rw = 0;
                end
            end else rw = 0;
            if (mem_wr_req) begin
                ww++;
                if (ww == 2) begin
                    mem_wr_ack = 1'b1;
                    backing[int'(mem_wr_addr)] = mem_wr_data;
                    last_wr_blk  = int'(mem_wr_addr);
                    last_wr_data = mem_wr_data;
                    wr_count++;
                    ww = 0;
                end
            end else ww = 0;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        for (int i = 0; i < LINES; i++) begin m_dm_v[i] = 0; m_dm_d[i] = 0; m_dm_b[i] = 0; end
        for (int s = 0; s < VB; s++) begin m_vb_v[s] = 0; m_vb_d[s] = 0; m_vb_b[s] = 0; end
        m_head = 0;
        expect_mem = backing;   // unwritten-back cache content is lost by reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one request; checks data, hit flag and memory traffic; returns latency
    task automatic access(int blk, int off, bit wr, logic [3:0] be, logic [31:0] wd,
                          string req, output int lat);
        bit ehit, ewb;
        logic [31:0] edata;
        int rd0 = rd_count, wr0 = wr_count;
        model_access(blk, wr, ehit, ewb);
        edata = exp_rd(blk);
        if (wr) begin edata = merge(edata, wd, be); expect_mem[blk] = edata; end
        req_addr  = ADDR_W'((blk << 2) | off);
        req_write = wr; req_be = be; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "busy after accept", req_ready, 0);
        lat = 0;
        while (!resp_valid && lat < 300) begin @(negedge clk); lat++; end
        check(resp_valid == 1'b1, req, "response arrived", resp_valid, 1);
        check(resp_rdata == edata, "R11", "data", resp_rdata, edata);
        check(resp_hit == ehit, req, "hit flag", resp_hit, ehit);
        check((rd_count - rd0) == (ehit ? 0 : 1), "R9", "memory reads", rd_count - rd0, ehit ? 0 : 1);
        check((wr_count - wr0) == (ewb ? 1 : 0), "R7", "memory writes", wr_count - wr0, ewb ? 1 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        int a0, x, y;
        int rd0;
        bit ok_all;
        void'($urandom(32'd20240607));
        do_reset();

        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
        check(mem_rd_req == 1'b0 && mem_wr_req == 1'b0, "R1", "memory idle", {mem_rd_req, mem_wr_req}, 0);

        // R1/R9: first access misses
        access(32'h41, 0, 0, 4'h0, 0, "R1", lat);
        // R3: primary hit timing; R2: offset ignored on reads
        access(32'h41, 3, 0, 4'h0, 0, "R3", lat);
        check(lat == 1, "R3", "primary hit latency", lat, 1);
        // R2/R6: byte-enable write, no memory write
        access(32'h41, 1, 1, 4'b0100, 32'hA1B2C3D4, "R6", lat);
        access(32'h41, 2, 0, 4'h0, 0, "R2", lat);
        check(resp_rdata[23:16] == 8'hB2, "R2", "byte lane 2 updated", resp_rdata[23:16], 8'hB2);

        // R5/R12: ping-pong between two blocks of one index
        x = (5 << IDX_W) | 9;
        y = (7 << IDX_W) | 9;
        access(x, 0, 1, 4'hF, 32'h11112222, "R12", lat);
        access(y, 0, 0, 4'h0, 0, "R12", lat);
        rd0 = rd_count;
        ok_all = 1;
        for (int i = 0; i < 10; i++) begin
            access((i % 2) ? y : x, 0, 0, 4'h0, 0, "R5", lat);
            if (lat != 2) ok_all = 0;
        end
        check(rd_count == rd0, "R12", "no reads during ping-pong", rd_count - rd0, 0);
        check(ok_all, "R5", "victim swap latency", ok_all, 1);

        // R8/R7: FIFO order and dirty write-back on a clean victim store
        do_reset();
        a0 = (1 << IDX_W) | 12;
        access(a0, 0, 1, 4'hF, 32'hDEADBEEF, "R6", lat);
        for (int t = 2; t <= 5; t++) access((t << IDX_W) | 12, 0, 0, 4'h0, 0, "R8", lat);
        check(wr_count == 0, "R7", "clean evictions silent", wr_count, 0);
        access((6 << IDX_W) | 12, 0, 0, 4'h0, 0, "R8", lat);
        check(last_wr_blk == a0, "R8", "oldest entry written back", last_wr_blk, a0);
        check(last_wr_data == 32'hDEADBEEF, "R7", "write-back data", last_wr_data, 32'hDEADBEEF);
        access((2 << IDX_W) | 12, 0, 0, 4'h0, 0, "R8", lat);
        check(resp_hit == 1'b1, "R8", "second-oldest survives", resp_hit, 1);
        access(a0, 0, 0, 4'h0, 0, "R11", lat);
        check(resp_rdata == 32'hDEADBEEF, "R11", "refetched dirty data", resp_rdata, 32'hDEADBEEF);

        // R4 and the rest: random traffic on crowded indices
        for (int n = 0; n < 3000; n++) begin
            int tg = int'($urandom_range(0, 7));
            int ix = int'($urandom_range(0, 3));
            bit w  = ($urandom_range(0, 9) < 4);
            access((tg << IDX_W) | ix, int'($urandom_range(0, 3)), w,
                   4'($urandom_range(1, 15)), $urandom, "R4", lat);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule